// File: doc/BRIEF.md
# Cascade-Sized Shift Rate Divider

This block produces the shift-enable strobe that paces a cascaded arithmetic unit. It runs from the unit's input clock. Its output is a one-cycle enable pulse, so no derived clock is ever formed and every consumer stays in the same clock domain.

When the prescale control is low, the strobe is asserted on every cycle. When it is high, the strobe rate is the input clock divided by a ratio. The ratio is not programmed directly: it is taken from the field that states how many slices are chained together. More slices give a slower strobe, which leaves a long carry path time to settle.

Any change to the control inputs restarts the divider phase from zero. The first strobe at the new rate therefore lands a fixed number of cycles after the change.

Top module: `shift_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, `shift_en` is low after that edge, and the divider phase restarts from zero.
- R2: With `presc_en` low and the controls unchanged since the previous edge, `shift_en` is high after every edge.
- R3: With `presc_en` high and `slice_sel` = 0 (one slice), `shift_en` pulses once every 2 cycles.
- R4: With `presc_en` high and `slice_sel` = 1 (two slices), `shift_en` pulses once every 4 cycles.
- R5: With `presc_en` high and `slice_sel` = 2 or 3 (three or four slices), `shift_en` pulses once every 8 cycles.
- R6: If `{presc_en, slice_sel}` at an edge differs from its value at the previous edge, `shift_en` is low after that edge and the phase restarts from zero.
- R7: With `presc_en` high, a `shift_en` pulse is never more than one cycle wide.
- R8: After a restart (R1 or R6) with the controls then held, the first pulse appears exactly N edges later, where N is the selected ratio (N = 1 when bypassed).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high clear of the pulse generator |
| presc_en | input | 1 | High selects the divided rate; low passes the clock rate |
| slice_sel | input | SEL_W (2) | Cascade size code: 0 = one slice, 1 = two, 2 = three, 3 = four |
| shift_en | output | 1 | Registered one-cycle shift enable |

## Verification
The hardest situation to reach is a control change that arrives in the middle of a divide period, just before the terminal phase would have produced a pulse. If the restart is mishandled, a stray or late pulse shows up there. The stimulus steps through all four size codes while the prescaler is on. It changes the code at varying offsets within the period, including one cycle before a pulse is due. It toggles the prescale bit on alternate cycles and applies a clear in mid-run. The behavioural phase model is compared against the output on every cycle.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // log2 of the divide ratio for a cascade size code, capped at max_log2
  function automatic int unsigned div_log2(input int unsigned code,
                                           input int unsigned max_log2);
    int unsigned l;
    l = code + 1;
    if (l > max_log2) l = max_log2;
    return l;
  endfunction
endpackage

// File: rtl/spc_cfg_watch.sv
module spc_cfg_watch #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CFG_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  output logic             cfg_chg
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  assign cfg_chg = !rst && (cfg != cfg_q);
endmodule

// File: rtl/spc_ratio_sel.sv
module spc_ratio_sel
  import spc_pkg::*;
#(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MAX_LOG2 = 3
) (
  input  logic                presc_on,
  input  logic [SEL_W-1:0]    sel,
  output logic [MAX_LOG2-1:0] term
);
  localparam int unsigned CODES = 1 << SEL_W;

  logic [MAX_LOG2-1:0] term_tab [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_tab
    localparam int unsigned L = div_log2(g, MAX_LOG2);
    assign term_tab[g] = MAX_LOG2'((1 << L) - 1);
  end

  always_comb begin
    term = '0;
    if (presc_on) term = term_tab[sel];
  end
endmodule

// File: rtl/spc_phase_cnt.sv
module spc_phase_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] phase_q,
  output logic             pulse_q
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else if (phase_q == term) begin
      phase_q <= '0;
      pulse_q <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/shift_prescaler.sv
module shift_prescaler #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MAX_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             presc_en,
  input  logic [SEL_W-1:0] slice_sel,
  output logic             shift_en
);
  logic                cfg_chg;
  logic [MAX_LOG2-1:0] term_w;
  logic [MAX_LOG2-1:0] phase_q;

  spc_cfg_watch #(.SEL_W(SEL_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .cfg     ({presc_en, slice_sel}),
    .cfg_chg (cfg_chg)
  );

  spc_ratio_sel #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_ratio (
    .presc_on (presc_en),
    .sel      (slice_sel),
    .term     (term_w)
  );

  spc_phase_cnt #(.CNT_W(MAX_LOG2)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_chg),
    .term    (term_w),
    .phase_q (phase_q),
    .pulse_q (shift_en)
  );
endmodule

// File: rtl/shift_prescaler_chk.sv
module shift_prescaler_chk #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MAX_LOG2 = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                presc_en,
  input logic [SEL_W-1:0]    slice_sel,
  input logic                shift_en,
  input logic [MAX_LOG2-1:0] phase_q,
  input logic [MAX_LOG2-1:0] term_w
);
  // R1: the edge that sees reset leaves the strobe low
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !shift_en);

  // R2: bypass with steady controls strobes every cycle
  a_r2_bypass_every: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(presc_en) &&
     $past({presc_en, slice_sel}) == $past({presc_en, slice_sel}, 2))
    |-> shift_en);

  // R6: a control change suppresses the strobe
  a_r6_change_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) &&
     $past({presc_en, slice_sel}) != $past({presc_en, slice_sel}, 2))
    |-> !shift_en);

  // R7: divided strobes are single-cycle
  a_r7_single_wide: assert property (@(posedge clk) disable iff (rst)
    (shift_en && presc_en) |=> !shift_en);

  // R8: the phase never passes the terminal value of a held setting
  a_r8_phase_bound: assert property (@(posedge clk) disable iff (rst)
    ($stable({presc_en, slice_sel}) && !$past(rst)) |-> (phase_q <= term_w));
endmodule

bind shift_prescaler shift_prescaler_chk #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .presc_en  (presc_en),
  .slice_sel (slice_sel),
  .shift_en  (shift_en),
  .phase_q   (phase_q),
  .term_w    (term_w)
);

// File: tb/shift_prescaler_tb.sv
module shift_prescaler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       presc_en = 1'b0;
  logic [1:0] slice_sel = 2'd0;
  logic       shift_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;

  // reference model state
  int    k = 0;
  logic  exp_en = 1'b0;
  logic  prev_exp = 1'b0;
  logic [2:0] prev_cfg = 3'd0;
  string tag = "R1";

  shift_prescaler u_dut (
    .clk(clk), .rst(rst), .presc_en(presc_en),
    .slice_sel(slice_sel), .shift_en(shift_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio_of(input logic p, input logic [1:0] s);
    if (!p) return 1;
    if (s == 2'd0) return 2;
    if (s == 2'd1) return 4;
    return 8;
  endfunction

  always @(posedge clk) begin
    int r;
    prev_exp = exp_en;
    cycles++;
    if (rst) begin
      k = 0; exp_en = 1'b0; tag = "R1";
      prev_cfg = {presc_en, slice_sel};
    end else if ({presc_en, slice_sel} != prev_cfg) begin
      k = 0; exp_en = 1'b0; tag = "R6";
      prev_cfg = {presc_en, slice_sel};
    end else begin
      k++;
      r = ratio_of(presc_en, slice_sel);
      exp_en = ((k % r) == 0);
      if (k == r) tag = "R8";
      else if (presc_en && prev_exp) tag = "R7";
      else if (!presc_en) tag = "R2";
      else if (slice_sel == 2'd0) tag = "R3";
      else if (slice_sel == 2'd1) tag = "R4";
      else tag = "R5";
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (shift_en !== exp_en) begin
        failures++;
        $display("FAIL %s cycle=%0d shift_en actual=%b expected=%b",
                 tag, cycles, shift_en, exp_en);
      end
    end
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input logic p, input logic [1:0] s, input int n);
    @(negedge clk);
    presc_en = p; slice_sel = s;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run(1'b0, 2'd0, 12);          // R2 bypass
    run(1'b1, 2'd0, 20);          // R3 one slice
    run(1'b1, 2'd1, 30);          // R4 two slices
    run(1'b1, 2'd2, 40);          // R5 three slices
    run(1'b1, 2'd3, 40);          // R5 four slices
    for (int off = 1; off <= 9; off++) begin   // R6 mid-period changes
      run(1'b1, 2'd2, off);
      run(1'b1, 2'd1, off);
    end
    run(1'b1, 2'd3, 7);           // R6 one cycle before pulse due
    run(1'b1, 2'd0, 5);
    for (int t = 0; t < 10; t++)  // R6 rapid prescale toggling
      run(t[0], 2'd1, 1);
    run(1'b1, 2'd2, 5);
    @(negedge clk); rst = 1'b1;   // R1 mid-run clear
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);   // R8 first pulse after clear
    run(1'b0, 2'd3, 10);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule